// File: doc/BRIEF.md
# ADC Result DMA Sequencer

This block works through a conversion list held in data memory and does not need the CPU for each sample. Every list entry is a two-byte slot. The upper nibble of the slot's first byte names the channel to convert. The block reads that channel ID and also reads the ID of the following slot. It then waits for a trigger, hands the channel to the converter interface and waits for the conversion to finish. The 16-bit result goes back into the same slot, so the list and the results share one memory area.

The list ends with a slot that repeats the last real channel, followed by a slot that holds the stop code 4'hF. Before each conversion the block checks the following slot. If that slot holds the stop code, the block converts nothing more, leaves the current slot alone, raises the completion flag and returns to idle. Software loads a 24-bit start pointer one byte at a time and then arms the block through a control register. Each conversion is started by a pulse on `trig`, which may come from a software request, a timer tick or an external pin.

Top module: `adc_dma_seq`

## Requirements
- R1: Register address 0 stages the low pointer byte and address 1 stages the middle byte. A write to address 2 commits {wdata, middle, low} as the 24-bit start pointer. Staged bytes alone never change the start pointer.
- R2: On the edge that takes a control write (address 3, bit 0 = 1) while idle, the block reads the slot byte at the pointer. On the next cycle it reads the byte at pointer+2. Read data is valid one cycle after `mem_rd`, and the ID is bits [7:4] of that data.
- R3: Three cycles after a slot starts, the block checks both IDs. If the current ID or the next ID is 4'hF, the block ends with no conversion and no write to the current slot. It sets `irq_flag` and drops `busy` on the same edge.
- R4: Otherwise the block waits for `trig`. On the edge after `trig`, it raises `adc_req` with `adc_chan` equal to the slot ID and holds both until `adc_done` is sampled.
- R5: On the two cycles after `adc_done`, the block writes {ID, data[11:8]} to the slot address and then data[7:0] to slot+1. The next slot starts at pointer+2.
- R6: `irq_flag` is set only when the list is complete. It stays set until a control write made while idle, with any bit 0 value, clears it.
- R7: `busy` is high from the edge after the arming write until completion. All register writes made while `busy` is high are ignored.
- R8: A `trig` pulse while busy, at any time other than the wait for a trigger, is dropped and sets the sticky `overrun` flag. A control write made while idle clears `overrun`. A `trig` while idle has no effect.
- R9: After reset, `busy`, `irq_flag`, `overrun`, `adc_req`, `mem_rd` and `mem_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 low, 1 middle, 2 high/commit, 3 control |
| reg_wdata | input | 8 | Register write data; control bit 0 arms |
| trig | input | 1 | Conversion start pulse |
| adc_req | output | 1 | Conversion request, held until done |
| adc_chan | output | 4 | Channel to convert |
| adc_done | input | 1 | Conversion finished pulse |
| adc_data | input | 12 | Conversion value, valid with adc_done |
| mem_addr | output | 24 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Read data, one cycle after mem_rd |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | List in progress |
| irq_flag | output | 1 | List complete flag |
| overrun | output | 1 | Sticky dropped-trigger flag |

## Verification
A register write or trigger takes effect on the next rising edge. Its result shows on the ports within that same cycle: after an arming write the first read is visible at once, the look-ahead read follows one cycle later, and the stop decision comes three cycles after the slot starts. The two result bytes appear one and two cycles after `adc_done` is sampled. The bench drives inputs on falling edges. Its behavioural model advances on each rising edge, and every output is compared with the model at the next falling edge, so each expected value is checked in the exact cycle it is due. After each list completes, the memory image is compared byte by byte, including the duplicate and stop slots, which must be unchanged.

// File: rtl/adc_dma_seq.sv
module adc_dma_seq #(
  parameter int ADDR_W = 24,
  parameter int ID_W   = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              trig,
  output logic              adc_req,
  output logic [ID_W-1:0]   adc_chan,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              irq_flag,
  output logic              overrun
);
  localparam logic [ID_W-1:0] STOP = '1;

  typedef enum logic [2:0] {
    S_IDLE, S_RDC, S_RDN, S_CHK, S_TRIG, S_CONV, S_WRH, S_WRL
  } state_t;

  state_t              state;
  logic [7:0]          lo_q, mid_q;
  logic [ADDR_W-1:0]   start_q, ptr_q;
  logic [ID_W-1:0]     cur_id;
  logic [DATA_W-1:0]   res_q;

  wire ctrl_wr  = reg_we && reg_addr == 2'd3;
  wire at_end   = cur_id == STOP || mem_rdata[7:8-ID_W] == STOP;

  assign busy     = state != S_IDLE;
  assign mem_rd   = state == S_RDC || state == S_RDN;
  assign mem_wr   = state == S_WRH || state == S_WRL;
  assign adc_req  = state == S_CONV;
  assign adc_chan = cur_id;
  assign mem_wdata = (state == S_WRH) ? {cur_id, res_q[DATA_W-1:8]} : res_q[7:0];

  always_comb begin
    case (state)
      S_RDN:   mem_addr = ptr_q + ADDR_W'(2);
      S_WRL:   mem_addr = ptr_q + ADDR_W'(1);
      default: mem_addr = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lo_q     <= '0;
      mid_q    <= '0;
      start_q  <= '0;
      ptr_q    <= '0;
      cur_id   <= '0;
      res_q    <= '0;
      irq_flag <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (trig && busy && state != S_TRIG) overrun <= 1'b1;
      case (state)
        S_IDLE: if (reg_we) begin
          case (reg_addr)
            2'd0: lo_q <= reg_wdata;
            2'd1: mid_q <= reg_wdata;
            2'd2: start_q <= ADDR_W'({reg_wdata, mid_q, lo_q});
            default: ;
          endcase
          if (ctrl_wr) begin
            irq_flag <= 1'b0;
            overrun  <= 1'b0;
            if (reg_wdata[0]) begin
              ptr_q <= start_q;
              state <= S_RDC;
            end
          end
        end
        S_RDC: state <= S_RDN;
        S_RDN: begin
          cur_id <= mem_rdata[7:8-ID_W];
          state  <= S_CHK;
        end
        S_CHK: if (at_end) begin
          irq_flag <= 1'b1;
          state    <= S_IDLE;
        end else begin
          state <= S_TRIG;
        end
        S_TRIG: if (trig) state <= S_CONV;
        S_CONV: if (adc_done) begin
          res_q <= adc_data;
          state <= S_WRH;
        end
        S_WRH: state <= S_WRL;
        S_WRL: begin
          ptr_q <= ptr_q + ADDR_W'(2);
          state <= S_RDC;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_dma_seq_chk.sv
module adc_dma_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int ID_W   = 4,
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              trig,
  input logic              adc_req,
  input logic [ID_W-1:0]   adc_chan,
  input logic              adc_done,
  input logic [DATA_W-1:0] adc_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic [7:0]        mem_rdata,
  input logic              mem_wr,
  input logic [7:0]        mem_wdata,
  input logic              busy,
  input logic              irq_flag,
  input logic              overrun
);
  assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_done) |=> adc_req && $stable(adc_chan));

  assert_byte_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |=> mem_wr && mem_addr == $past(mem_addr) + ADDR_W'(1));

  assert_irq_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> !busy && $fell(busy));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd && !mem_wr && !adc_req);

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !(reg_we && reg_addr == 2'd3)) |=> overrun);
endmodule

bind adc_dma_seq adc_dma_seq_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/adc_dma_seq_tb.sv
module adc_dma_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        trig = 1'b0;
  logic        adc_req;
  logic [3:0]  adc_chan;
  logic        adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic [23:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = '0;
  logic        mem_wr;
  logic [7:0]  mem_wdata;
  logic        busy, irq_flag, overrun;

  adc_dma_seq u_dut (.*);

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0, conv_n = 0, acnt = 0;
  logic [7:0] mem [256];
  logic [7:0] m_ref [256];

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  // converter: done after 3 request cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      adc_done <= 1'b0;
      acnt <= 0;
    end else if (adc_req && !adc_done) begin
      if (acnt == 2) begin
        adc_done <= 1'b1;
        adc_data <= 12'(conv_n * 37 + 419);
        conv_n <= conv_n + 1;
        acnt <= 0;
      end else acnt <= acnt + 1;
    end else adc_done <= 1'b0;
  end

  // behavioural reference: 0 idle,1 read cur,2 read next,3 decide,4 await trigger,5 convert,6 hi byte,7 lo byte
  int m_ph = 0;
  logic m_irq = 0, m_ovr = 0;
  logic [23:0] m_ptr = 0, m_start = 0;
  logic [7:0]  m_lo = 0, m_mid = 0;
  logic [3:0]  m_cur = 0;
  logic [11:0] m_res = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_irq = 0; m_ovr = 0; m_ptr = 0; m_start = 0; m_lo = 0; m_mid = 0;
    end else begin
      int old;
      old = m_ph;
      if (trig && old != 0 && old != 4) m_ovr = 1;
      if (old == 0 && reg_we) begin
        if (reg_addr == 0) m_lo = reg_wdata;
        else if (reg_addr == 1) m_mid = reg_wdata;
        else if (reg_addr == 2) m_start = {reg_wdata, m_mid, m_lo};
        else begin
          m_irq = 0; m_ovr = 0;
          if (reg_wdata[0]) begin m_ptr = m_start; m_ph = 1; end
        end
      end
      case (old)
        1: m_ph = 2;
        2: m_ph = 3;
        3: begin
          m_cur = m_ref[m_ptr[7:0]][7:4];
          if (m_cur == 4'hF || m_ref[8'(m_ptr[7:0] + 8'd2)][7:4] == 4'hF) begin
            m_ph = 0; m_irq = 1;
          end else m_ph = 4;
        end
        4: if (trig) m_ph = 5;
        5: if (adc_done) begin m_res = adc_data; m_ph = 6; end
        6: begin m_ref[m_ptr[7:0]] = {m_cur, m_res[11:8]}; m_ph = 7; end
        7: begin m_ref[8'(m_ptr[7:0] + 8'd1)] = m_res[7:0]; m_ptr = m_ptr + 2; m_ph = 1; end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R7 busy", 32'(busy), 32'(m_ph != 0));
      chk("R6 irq_flag", 32'(irq_flag), 32'(m_irq));
      chk("R8 overrun", 32'(overrun), 32'(m_ovr));
      chk("R4 adc_req", 32'(adc_req), 32'(m_ph == 5));
      if (m_ph == 5) chk("R4 adc_chan", 32'(adc_chan), 32'(m_cur));
      chk("R2 mem_rd", 32'(mem_rd), 32'(m_ph == 1 || m_ph == 2));
      chk("R5 mem_wr", 32'(mem_wr), 32'(m_ph == 6 || m_ph == 7));
      if (m_ph == 1 || m_ph == 6) chk("R2 mem_addr", 32'(mem_addr), 32'(m_ptr));
      if (m_ph == 2) chk("R2 mem_addr next", 32'(mem_addr), 32'(m_ptr + 2));
      if (m_ph == 7) chk("R5 mem_addr low", 32'(mem_addr), 32'(m_ptr + 1));
      if (m_ph == 6) chk("R5 hi byte", 32'(mem_wdata), 32'({m_cur, m_res[11:8]}));
      if (m_ph == 7) chk("R5 lo byte", 32'(mem_wdata), 32'(m_res[7:0]));
    end
  end

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 500) begin @(negedge clk); n++; end
    chk("R3 list completes", 32'(busy), 32'd0);
  endtask

  task automatic image_check(string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== m_ref[i]) bad++;
    chk(tag, 32'(bad), 32'd0);
  endtask

  task automatic put(int a, logic [7:0] v);
    mem[a] = v; m_ref[a] = v;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) put(i, 8'h00);
    put(8'h40, 8'h20); put(8'h42, 8'h50); put(8'h44, 8'h80);
    put(8'h46, 8'h30); put(8'h48, 8'h30); put(8'h4A, 8'hF0);
    put(8'h80, 8'h70); put(8'h82, 8'h70); put(8'h84, 8'hF0);
    put(8'h90, 8'h90); put(8'h92, 8'hF0);

    repeat (5) @(negedge clk);
    chk("R9 busy after reset", 32'(busy), 0);
    chk("R9 irq after reset", 32'(irq_flag), 0);
    chk("R9 overrun after reset", 32'(overrun), 0);
    chk("R9 strobes after reset", 32'({adc_req, mem_rd, mem_wr}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // list A at 0x123440: channels 2,5,8,3 then duplicate 3 and stop
    wr_reg(0, 8'h40); wr_reg(1, 8'h34); wr_reg(2, 8'h12);
    wr_reg(3, 8'h01);
    chk("R2 first read address", 32'(mem_addr), 32'h123440);
    chk("R7 busy after arm", 32'(busy), 1);
    repeat (18) @(negedge clk);
    pulse_trig();
    wr_reg(0, 8'h99); wr_reg(1, 8'h99); wr_reg(2, 8'h99);
    repeat (16) @(negedge clk);
    pulse_trig(); @(negedge clk); pulse_trig();
    chk("R8 overrun on trigger during conversion", 32'(overrun), 1);
    repeat (16) @(negedge clk);
    pulse_trig();
    chk("R6 no flag mid-list", 32'(irq_flag), 0);
    repeat (18) @(negedge clk);
    pulse_trig();
    wait_idle();
    chk("R6 flag at completion", 32'(irq_flag), 1);
    chk("R3 duplicate slot untouched", 32'({mem[8'h48], mem[8'h49]}), 32'h3000);
    chk("R3 stop slot untouched", 32'({mem[8'h4A], mem[8'h4B]}), 32'hF000);
    chk("R5 slot 0 high nibble keeps ID", 32'(mem[8'h40][7:4]), 2);
    chk("R5 slot 3 high nibble keeps ID", 32'(mem[8'h46][7:4]), 3);
    chk("R4 four conversions", 32'(conv_n), 4);
    image_check("R5 memory image list A");

    // clear flags, trigger while idle is ignored
    wr_reg(3, 8'h00);
    chk("R6 flag cleared by control write", 32'(irq_flag), 0);
    chk("R8 overrun cleared", 32'(overrun), 0);
    pulse_trig();
    chk("R8 idle trigger no overrun", 32'(overrun), 0);
    chk("R8 idle trigger no start", 32'(busy), 0);

    // stage low/mid only; busy-time writes were ignored, start unchanged
    wr_reg(0, 8'h80); wr_reg(1, 8'h00);
    wr_reg(3, 8'h01);
    chk("R1 R7 start pointer unchanged", 32'(mem_addr), 32'h123440);
    for (int k = 0; k < 4; k++) begin
      repeat (18) @(negedge clk);
      pulse_trig();
    end
    wait_idle();
    chk("R4 eight conversions", 32'(conv_n), 8);
    image_check("R5 memory image rerun");

    // commit high byte -> 0x000080: one conversion then stop
    wr_reg(2, 8'h00);
    wr_reg(3, 8'h01);
    chk("R1 committed pointer", 32'(mem_addr), 32'h000080);
    repeat (10) @(negedge clk);
    pulse_trig();
    wait_idle();
    chk("R4 single conversion", 32'(conv_n), 9);
    chk("R3 second slot untouched", 32'({mem[8'h82], mem[8'h83]}), 32'h7000);
    image_check("R5 memory image list C");

    // list with only duplicate+stop: nothing converted
    wr_reg(0, 8'h90); wr_reg(1, 8'h00); wr_reg(2, 8'h00);
    wr_reg(3, 8'h01);
    wait_idle();
    chk("R3 immediate stop flag", 32'(irq_flag), 1);
    chk("R3 no conversion", 32'(conv_n), 9);
    chk("R3 slot untouched", 32'(mem[8'h90]), 32'h90);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 100000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule